// File: doc/BRIEF.md
# Serial Frame Word Assembler

This block sits behind the register read path of a UART and turns a stream of received bytes into memory write requests. Each request is carried by a frame of exactly six bytes. The first two bytes form a 16-bit address and the last four form a 32-bit data word, each field sent most significant byte first. A byte counts as received only when the bus controller pulses its read chip-select while its write/read qualifier selects a read.

When the sixth byte lands, the assembled address and data appear on registered outputs and a ready flag goes high. Both stay frozen until the memory side returns an acknowledge strobe. While a word is waiting, the assembler refuses further bytes, so a new frame cannot be mixed into the pending one. After the acknowledge, the next accepted byte is the first byte of a new frame.

Top module: `frame_word_assembler`

## Requirements
- R1: Ready rises on the clock edge that accepts the sixth byte of a frame. It stays low after one to five accepted bytes.
- R2: A byte is accepted on a rising clock edge only when `rd_cs` is 1 and `wr_sel` is 0 (0 means read). A strobe with `wr_sel` at 1, or a cycle with `rd_cs` at 0, leaves the frame unchanged.
- R3: Byte 1 sets `word_addr[15:8]` and byte 2 sets `word_addr[7:0]`. Bytes 3 to 6 set `word_data[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`, in that order.
- R4: While `word_ready` is 1 and `word_ack` is 0, `word_ready`, `word_addr` and `word_data` keep their values.
- R5: When `word_ack` is 1 while `word_ready` is 1, `word_ready` is 0 after that edge. `word_addr` and `word_data` keep the acknowledged values.
- R6: Read strobes arriving while `word_ready` is 1 are ignored. This includes a strobe in the same cycle as the acknowledge. None of those bytes appears in the next frame.
- R7: After an acknowledge, the next six accepted bytes form a complete new frame. Idle cycles between the bytes of a frame do not disturb it.
- R8: A synchronous active-high `rst` clears the byte count, both outputs and `word_ready`. A partly received frame is discarded.
- R9: `word_ack` while `word_ready` is 0 has no effect on the outputs or on a partly received frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Byte from the UART read data path |
| rd_cs | input | 1 | Chip-select strobe of a bus read cycle |
| wr_sel | input | 1 | Write/read qualifier, 1 = write, 0 = read |
| word_addr | output | 16 | Assembled address |
| word_data | output | 32 | Assembled data word |
| word_ready | output | 1 | Assembled word waiting for memory |
| word_ack | input | 1 | Memory side has taken the word |

## Verification
The bench aims at the points where a frame could be corrupted:
- Strobes sent while a word is pending, including one in the same cycle as the acknowledge. A design that let these in would start the next frame shifted by one byte, which shows up in its address.
- Write-qualified strobes. A design that took them would complete a frame early.
- A reset in the middle of a frame, and an acknowledge with nothing pending. A design that failed either one would let old bytes leak into the following word.
- Frames sent with gaps between bytes, to catch counters that advance on idle cycles.

// File: rtl/fwa_pkg.sv
package fwa_pkg;
  function automatic int fwa_cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fwa_strobe_qual.sv
module fwa_strobe_qual (
  input  logic rd_cs,
  input  logic wr_sel,
  input  logic busy,
  output logic accept
);
  // a byte is taken on a read strobe, never while a word waits
  always_comb accept = rd_cs & ~wr_sel & ~busy;
endmodule

// File: rtl/fwa_byte_counter.sv
module fwa_byte_counter #(
  parameter int FRAME_BYTES = 6,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

  always_comb last = accept & (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (accept) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_IDX); // R1
  AST_HOLD_FREEZES_COUNT: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cnt)); // R6
endmodule

// File: rtl/fwa_shift_reg.sv
module fwa_shift_reg #(
  parameter int BYTE_W  = 8,
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [BYTE_W-1:0]  din,
  output logic [FRAME_W-1:0] frame
);
  logic [FRAME_W-BYTE_W-1:0] hist;

  // earlier bytes move toward the top, so the first byte ends up most significant
  always_comb frame = {hist, din};

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else if (accept) hist <= frame[FRAME_W-BYTE_W-1:0];
  end
endmodule

// File: rtl/fwa_hold_reg.sv
module fwa_hold_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [ADDR_W+DATA_W-1:0] frame,
  input  logic                     ack,
  output logic [ADDR_W-1:0]        addr_q,
  output logic [DATA_W-1:0]        data_q,
  output logic                     ready_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      data_q  <= '0;
      ready_q <= 1'b0;
    end else if (load) begin
      addr_q  <= frame[ADDR_W+DATA_W-1:DATA_W];
      data_q  <= frame[DATA_W-1:0];
      ready_q <= 1'b1;
    end else if (ready_q && ack) begin
      ready_q <= 1'b0;
    end
  end

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready_q && !ack |=> ready_q); // R4
  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
    ready_q && !ack |=> $stable(addr_q) && $stable(data_q)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ready_q && ack |=> !ready_q); // R5
  AST_ACK_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
    ready_q && ack |=> $stable(addr_q) && $stable(data_q)); // R5
  AST_NO_LOAD_WHILE_READY: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> !load); // R6
endmodule

// File: rtl/frame_word_assembler.sv
module frame_word_assembler #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [BYTE_W-1:0]            rx_byte,
  input  logic                         rd_cs,
  input  logic                         wr_sel,
  output logic [ADDR_BYTES*BYTE_W-1:0] word_addr,
  output logic [DATA_BYTES*BYTE_W-1:0] word_data,
  output logic                         word_ready,
  input  logic                         word_ack
);
  localparam int FRAME_BYTES = ADDR_BYTES + DATA_BYTES;
  localparam int ADDR_W      = ADDR_BYTES * BYTE_W;
  localparam int DATA_W      = DATA_BYTES * BYTE_W;
  localparam int FRAME_W     = ADDR_W + DATA_W;
  localparam int CNT_W       = fwa_pkg::fwa_cnt_w(FRAME_BYTES);

  logic               accept;
  logic               last;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] frame;

  fwa_strobe_qual u_qual (
    .rd_cs  (rd_cs),
    .wr_sel (wr_sel),
    .busy   (word_ready),
    .accept (accept)
  );

  fwa_byte_counter #(.FRAME_BYTES(FRAME_BYTES), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .hold   (word_ready),
    .cnt    (cnt),
    .last   (last)
  );

  fwa_shift_reg #(.BYTE_W(BYTE_W), .FRAME_W(FRAME_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .din    (rx_byte),
    .frame  (frame)
  );

  fwa_hold_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (last),
    .frame   (frame),
    .ack     (word_ack),
    .addr_q  (word_addr),
    .data_q  (word_data),
    .ready_q (word_ready)
  );

  AST_READY_ON_LAST_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(word_ready) |-> $past(cnt) == CNT_W'(FRAME_BYTES - 1)); // R1
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    rd_cs && wr_sel |=> $stable(cnt)); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !word_ready && cnt == '0 && word_addr == '0 && word_data == '0); // R8
endmodule

// File: tb/frame_word_assembler_bench.sv
module frame_word_assembler_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_byte = '0;
  logic        rd_cs = 1'b0;
  logic        wr_sel = 1'b0;
  logic        word_ack = 1'b0;
  logic [15:0] word_addr;
  logic [31:0] word_data;
  logic        word_ready;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  frame_word_assembler u_frame_word_assembler (
    .clk        (clk),
    .rst        (rst),
    .rx_byte    (rx_byte),
    .rd_cs      (rd_cs),
    .wr_sel     (wr_sel),
    .word_addr  (word_addr),
    .word_data  (word_data),
    .word_ready (word_ready),
    .word_ack   (word_ack)
  );

  // frames as sent on the wire: first byte in bits 47:40; gap is the number of idle cycles between bytes
  localparam int NV = 5;
  localparam logic [47:0] VEC_FRAME [NV] = '{
    48'h1234_DEADBEEF, 48'h0000_00000000, 48'hFFFF_FFFFFFFF,
    48'hA55A_0F1E2D3C, 48'h0102_03040506 };
  localparam int VEC_GAP [NV] = '{0, 1, 3, 0, 2};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic wr, input int gap);
    @(negedge clk);
    rx_byte = b; rd_cs = 1'b1; wr_sel = wr;
    @(negedge clk);
    rd_cs = 1'b0; wr_sel = 1'b0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [47:0] f, input int gap, input string req);
    for (int i = 0; i < 6; i++) begin
      if (i == 5) chk({req, " ready low before sixth byte"}, word_ready, 1'b0);
      send_byte(f[47-8*i -: 8], 1'b0, gap);
    end
  endtask

  task automatic do_ack();
    @(negedge clk);
    word_ack = 1'b1;
    @(negedge clk);
    word_ack = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset ready", word_ready, 1'b0);
    chk("R8 reset addr", word_addr, 16'h0);
    chk("R8 reset data", word_data, 32'h0);

    // table walk: R1 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC_FRAME[v], VEC_GAP[v], "R1");
      chk("R1 ready after sixth byte", word_ready, 1'b1);
      chk("R3 addr", word_addr, VEC_FRAME[v][47:32]);
      chk("R3 data", word_data, VEC_FRAME[v][31:0]);
      repeat (3) @(negedge clk);
      chk("R4 ready held", word_ready, 1'b1);
      chk("R4 addr held", word_addr, VEC_FRAME[v][47:32]);
      do_ack();
      chk("R5 ready cleared", word_ready, 1'b0);
      chk("R5 data kept", word_data, VEC_FRAME[v][31:0]);
    end

    // R2: write strobes must not count
    send_byte(8'h11, 1'b0, 0);
    send_byte(8'hEE, 1'b1, 0);
    send_byte(8'h22, 1'b0, 1);
    for (int i = 0; i < 3; i++) send_byte(8'hEE, 1'b1, 0);
    send_byte(8'h33, 1'b0, 0);
    send_byte(8'h44, 1'b0, 0);
    send_byte(8'h55, 1'b0, 0);
    chk("R2 ready low after five reads", word_ready, 1'b0);
    send_byte(8'h66, 1'b0, 0);
    chk("R2 frame excludes writes", {word_addr, word_data}, 48'h1122_33445566);

    // R6: strobes while pending ignored, including the acknowledge cycle
    send_byte(8'h99, 1'b0, 0);
    send_byte(8'h98, 1'b0, 0);
    @(negedge clk);
    word_ack = 1'b1; rd_cs = 1'b1; rx_byte = 8'h97;
    @(negedge clk);
    word_ack = 1'b0; rd_cs = 1'b0;
    chk("R6 addr unchanged by pending strobes", word_addr, 16'h1122);
    chk("R6 ready cleared", word_ready, 1'b0);
    send_frame(48'hCAFE_12345678, 0, "R6");
    chk("R6 next frame clean", {word_addr, word_data}, 48'hCAFE_12345678);
    do_ack();

    // R9: ack with nothing pending, mid-frame
    send_byte(8'hAB, 1'b0, 0);
    send_byte(8'hCD, 1'b0, 0);
    do_ack();
    chk("R9 ack idle keeps ready low", word_ready, 1'b0);
    chk("R9 ack idle keeps data", word_data, 32'h12345678);
    send_byte(8'h01, 1'b0, 0);
    send_byte(8'h02, 1'b0, 0);
    send_byte(8'h03, 1'b0, 0);
    send_byte(8'h04, 1'b0, 0);
    chk("R9 partial frame survives", {word_ready, word_addr, word_data}, {1'b1, 48'hABCD_01020304});
    do_ack();

    // R8: reset mid-frame discards partial bytes
    send_byte(8'h77, 1'b0, 0);
    send_byte(8'h78, 1'b0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 reset clears addr", word_addr, 16'h0);
    send_frame(48'h4242_00C0FFEE, 0, "R8");
    chk("R8 frame after reset", {word_ready, word_addr, word_data}, {1'b1, 48'h4242_00C0FFEE});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule